// File: doc/BRIEF.md
# Dual Programmable Timer with Cascade and Event Counting

This block holds two 8-bit down-counters, each advanced by its own prescaler. A prescaler takes one of two oscillator clock enables and divides it by 1, 4, 16 or 64. When a counter reaches zero, the next advance reloads it from its reload register and raises that channel's underflow flag for one clock. A single mode bit joins the two counters into one 16-bit counter. In that mode channel 1 only advances when channel 0 underflows, and channel 1's prescaler settings are ignored.

Channel 0 has two further functions. In event-counter mode it counts falling edges of an external event input and ignores its own prescaler. A function bit then chooses between the raw event input and a pre-filtered copy supplied by a separate noise filter. In timer mode, the same function bit turns on pulse-width measurement: prescaled ticks are counted only while the raw event input is high.

Software configures the block through a simple write port and observes it through a combinational read port. The read port returns the configuration registers and both live counter values.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset all configuration fields, reload values and both counters are 0, and both underflow flags are 0.
- R2: Address map: 0 = control, with bit0 join16, bit1 clk_sel0, bit2 clk_sel1, bit3 event_mode and bit4 func0; 1 = ratios, with bits[1:0] ratio0 and bits[3:2] ratio1; 2 = reload0; 3 = reload1. Reading address 4 returns count0 and address 5 returns count1. Unused bits read 0, and writes to addresses 4 to 7 change nothing.
- R3: A prescaler whose clock select is 0 counts slow_tick cycles, and one whose clock select is 1 counts fast_tick cycles.
- R4: Ratio code 00, 01, 10 and 11 produces one counter advance per 1, 4, 16 and 64 selected source ticks, counted from a free-running 6-bit source-tick count that is cleared only by reset.
- R5: On an advance, a nonzero counter decrements. A zero counter loads its reload value instead and sets its underflow flag for exactly the following clock cycle. Writing a reload value does not change the counter.
- R6: With join16 = 1, channel 1 advances only on a channel 0 underflow. uflow0 stays 0 from the cycle after join16 is set, uflow1 marks the 16-bit underflow, and clk_sel1 and ratio1 have no effect.
- R7: With event_mode = 1, channel 0 advances once per falling edge of the selected event source. The edge takes effect at the third rising clock edge after the input changes, and clk_sel0 and ratio0 have no effect.
- R8: With event_mode = 1, func0 = 1 selects evt_clean as the event source, and func0 = 0 selects evt_raw.
- R9: With event_mode = 0 and func0 = 1, channel 0 advances on a prescaled tick only while evt_raw, delayed by two clock edges, is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| slow_tick | input | 1 | Low-speed oscillator clock enable |
| fast_tick | input | 1 | High-speed oscillator clock enable |
| evt_raw | input | 1 | External event input, unfiltered |
| evt_clean | input | 1 | Same input after the external noise filter |
| uflow0 | output | 1 | Channel 0 underflow pulse |
| uflow1 | output | 1 | Channel 1 (or 16-bit) underflow pulse |

## Verification
The critical coincidence is a channel 0 underflow in the same cycle as a channel 1 advance. In 16-bit mode this coincidence is the carry itself. In split mode it comes from two independent prescaler ticks landing together, and it can also meet a configuration write on the same edge. Random phases hold fast_tick high often, use small reload values and rewrite the control register while the counters run, so underflows, carries and mode changes often fall in one cycle. A cycle-level reference model in the bench judges each flag on every cycle and each counter at the end of every phase.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int PSW = 6;

  // bit0 join16, bit1 clk_sel0, bit2 clk_sel1, bit3 event_mode, bit4 func0
  typedef struct packed {
    logic func0;
    logic event_mode;
    logic clk_sel1;
    logic clk_sel0;
    logic join16;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_RATIO = 3'd1;
  localparam logic [2:0] A_REL0  = 3'd2;
  localparam logic [2:0] A_REL1  = 3'd3;
  localparam logic [2:0] A_CNT0  = 3'd4;
  localparam logic [2:0] A_CNT1  = 3'd5;

  // low-bit mask of the source-tick count: 1, 4, 16 or 64 ticks per advance
  function automatic logic [PSW-1:0] ratio_mask(input logic [1:0] code);
    logic [PSW:0] one_hot;
    one_hot = (PSW+1)'(1) << (2 * code);
    return PSW'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/dtu_prescaler.sv
module dtu_prescaler
  import dtu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_en,
  input  logic       fast_en,
  input  logic       sel_fast,
  input  logic [1:0] ratio,
  output logic       tick
);
  logic           src_en;
  logic [PSW-1:0] src_cnt;
  logic [PSW-1:0] mask;

  assign src_en = sel_fast ? fast_en : slow_en;
  assign mask   = ratio_mask(ratio);
  assign tick   = src_en && ((src_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)      src_cnt <= '0;
    else if (src_en) src_cnt <= src_cnt + 1'b1;
  end

  // R4: with a divider above 1 and an unchanged ratio, ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mask != '0) |=> (!tick || !$stable(mask)));

  // R3: no tick without a source tick since the last edge
  a_r3_no_src_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |-> !tick);
endmodule

// File: rtl/dtu_evt_front.sv
module dtu_evt_front (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_raw,
  input  logic evt_clean,
  input  logic use_clean,
  output logic level,
  output logic fall
);
  logic       src;
  logic [2:0] sync_q;

  assign src = use_clean ? evt_clean : evt_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], src};
  end

  assign level = sync_q[1];
  assign fall  = sync_q[2] & ~sync_q[1];

  // R7: a falling edge is a single-cycle event
  a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dtu_down_cnt.sv
module dtu_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = adv && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= reload;
    else if (adv)  count <= count - 1'b1;
  end

  // R5: reload on a zero advance, decrement otherwise, hold without advance
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && count == '0) |=> count == $past(reload));
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && count != '0) |=> count == $past(count) - 1'b1);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(count));
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          slow_tick,
  input  logic          fast_tick,
  input  logic          evt_raw,
  input  logic          evt_clean,
  output logic          uflow0,
  output logic          uflow1
);
  ctrl_t         ctrl;
  logic [1:0]    ratio0, ratio1;
  logic [CW-1:0] reload0, reload1;
  logic [CW-1:0] count0, count1;

  // named internal events for the assertions
  logic pre0_tick, pre1_tick;
  logic ev_level, ev_fall;
  logic adv0, adv1;
  logic wrap0, wrap1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      ratio0  <= '0;
      ratio1  <= '0;
      reload0 <= '0;
      reload1 <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_RATIO: {ratio1, ratio0} <= wr_data[3:0];
        A_REL0:  reload0 <= wr_data;
        A_REL1:  reload1 <= wr_data;
        default: ;
      endcase
    end
  end

  dtu_prescaler u_pre0 (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_tick), .fast_en(fast_tick),
    .sel_fast(ctrl.clk_sel0), .ratio(ratio0), .tick(pre0_tick));

  dtu_prescaler u_pre1 (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_tick), .fast_en(fast_tick),
    .sel_fast(ctrl.clk_sel1), .ratio(ratio1), .tick(pre1_tick));

  dtu_evt_front u_evt (
    .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .evt_clean(evt_clean),
    .use_clean(ctrl.event_mode & ctrl.func0), .level(ev_level), .fall(ev_fall));

  always_comb begin
    if (ctrl.event_mode) adv0 = ev_fall;
    else                 adv0 = pre0_tick && (!ctrl.func0 || ev_level);
  end

  assign adv1 = ctrl.join16 ? wrap0 : pre1_tick;

  dtu_down_cnt #(.W(CW)) u_cnt0 (
    .clk(clk), .rst_n(rst_n), .adv(adv0), .reload(reload0),
    .count(count0), .wrap(wrap0));

  dtu_down_cnt #(.W(CW)) u_cnt1 (
    .clk(clk), .rst_n(rst_n), .adv(adv1), .reload(reload1),
    .count(count1), .wrap(wrap1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uflow0 <= 1'b0;
      uflow1 <= 1'b0;
    end else begin
      uflow0 <= wrap0 && !ctrl.join16;
      uflow1 <= wrap1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = CW'(ctrl);
      A_RATIO: rd_data = CW'({ratio1, ratio0});
      A_REL0:  rd_data = reload0;
      A_REL1:  rd_data = reload1;
      A_CNT0:  rd_data = count0;
      A_CNT1:  rd_data = count1;
      default: rd_data = '0;
    endcase
  end

  // R6: joined mode silences the low flag and gates the high counter
  a_r6_low_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl.join16) |-> !uflow0);
  a_r6_high_waits_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.join16 && !wrap0) |=> $stable(count1));
  // R7: in event mode only a falling edge moves channel 0
  a_r7_prescaler_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.event_mode && !ev_fall) |=> $stable(count0));
  // R9: pulse-width mode holds while the input is low
  a_r9_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.event_mode && ctrl.func0 && !ev_level) |=> $stable(count0));
  // R5: a flag follows an underflow
  a_r5_flag_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    uflow1 |-> $past(wrap1));
endmodule

// File: tb/sim_dual_timer_unit.sv
module sim_dual_timer_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       slow_tick = 0, fast_tick = 0, evt_raw = 1, evt_clean = 1;
  logic       uflow0, uflow1;

  int tests = 0, fails = 0, prints = 0;
  bit done = 0;
  bit rnd_ticks = 0, rnd_evt = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dual_timer_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .evt_raw(evt_raw), .evt_clean(evt_clean), .uflow0(uflow0), .uflow1(uflow1));

  // ---------------- reference model ----------------
  logic [4:0] m_ctrl;   // {func0, event_mode, clk_sel1, clk_sel0, join16}
  logic [3:0] m_ratio;
  logic [7:0] m_rel0, m_rel1, m_c0, m_c1;
  logic [5:0] m_pc0, m_pc1;
  logic [2:0] m_sync;
  logic       m_f0, m_f1;

  function automatic int divisor(input logic [1:0] code);
    case (code)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 16;
      default: return 64;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic s0, s1, t0, t1, p0, p1, fall, lvl, w0, w1, ev_src;
    if (!rst_n) begin
      m_ctrl <= 0; m_ratio <= 0; m_rel0 <= 0; m_rel1 <= 0;
      m_c0 <= 0; m_c1 <= 0; m_pc0 <= 0; m_pc1 <= 0; m_sync <= 0;
      m_f0 <= 0; m_f1 <= 0;
    end else begin
      s0 = m_ctrl[1] ? fast_tick : slow_tick;
      s1 = m_ctrl[2] ? fast_tick : slow_tick;
      p0 = s0 && (int'(m_pc0) % divisor(m_ratio[1:0]) == divisor(m_ratio[1:0]) - 1);
      p1 = s1 && (int'(m_pc1) % divisor(m_ratio[3:2]) == divisor(m_ratio[3:2]) - 1);
      if (s0) m_pc0 <= m_pc0 + 1;
      if (s1) m_pc1 <= m_pc1 + 1;
      ev_src = (m_ctrl[3] && m_ctrl[4]) ? evt_clean : evt_raw;
      m_sync <= {m_sync[1:0], ev_src};
      fall = m_sync[2] && !m_sync[1];
      lvl  = m_sync[1];
      t0 = m_ctrl[3] ? fall : (p0 && (!m_ctrl[4] || lvl));
      w0 = t0 && m_c0 == 0;
      if (t0) m_c0 <= (m_c0 == 0) ? m_rel0 : m_c0 - 1;
      t1 = m_ctrl[0] ? w0 : p1;
      w1 = t1 && m_c1 == 0;
      if (t1) m_c1 <= (m_c1 == 0) ? m_rel1 : m_c1 - 1;
      m_f0 <= w0 && !m_ctrl[0];
      m_f1 <= w1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl  <= wr_data[4:0];
          3'd1: m_ratio <= wr_data[3:0];
          3'd2: m_rel0  <= wr_data;
          3'd3: m_rel1  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle flag comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (uflow0 !== m_f0 || uflow1 !== m_f1) begin
        fails++;
        if (prints < 20) begin
          prints++;
          $display("FAIL %s flags got u0=%b u1=%b expected u0=%b u1=%b at %0t",
                   cur_req, uflow0, uflow1, m_f0, m_f1, $time);
        end
      end
    end
  end

  // random stimulus drivers
  always @(negedge clk) begin
    if (rnd_ticks) begin
      slow_tick <= ($urandom % 6) == 0;
      fast_tick <= ($urandom % 4) != 0;
    end
    if (rnd_evt) begin
      if ($urandom % 5 == 0) evt_raw   <= ~evt_raw;
      if ($urandom % 7 == 0) evt_clean <= ~evt_clean;
    end
  end

  // ---------------- tasks ----------------
  task automatic check(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic do_reset();
    rnd_ticks = 0; rnd_evt = 0;
    @(negedge clk);
    slow_tick = 0; fast_tick = 0; evt_raw = 1; evt_clean = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic check_counts(input string req);
    logic [7:0] v;
    rd(3'd4, v); check(req, "count0", v, m_c0);
    rd(3'd5, v); check(req, "count1", v, m_c1);
  endtask

  // ---------------- main ----------------
  initial begin
    logic [7:0] v;
    int n0, n1;
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); check("R1", $sformatf("reset read addr %0d", a), v, 0);
    end
    check("R1", "uflow0 at reset", uflow0, 0);
    check("R1", "uflow1 at reset", uflow1, 0);

    // R2 register map and read masking
    cur_req = "R2";
    wr(3'd0, 8'hE0); rd(3'd0, v); check("R2", "ctrl unused bits", v, 0);
    wr(3'd1, 8'hF6); rd(3'd1, v); check("R2", "ratio field", v, 8'h06);
    wr(3'd2, 8'hA5); rd(3'd2, v); check("R2", "reload0", v, 8'hA5);
    wr(3'd3, 8'h3C); rd(3'd3, v); check("R2", "reload1", v, 8'h3C);
    wr(3'd4, 8'h77); wr(3'd6, 8'h11);
    rd(3'd4, v); check("R2", "write to count0 ignored", v, 0);
    rd(3'd0, v); check("R2", "ctrl after stray writes", v, 0);

    // R6 directed: 16-bit cascade, fast every cycle, reload {1,0}
    do_reset();
    cur_req = "R6";
    wr(3'd0, 8'h03);      // join16, clk_sel0 fast
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h0C);      // ratio1=11 must not matter
    n0 = 0; n1 = 0;
    fast_tick = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      n0 += uflow0; n1 += uflow1;
    end
    fast_tick = 0;
    check("R6", "uflow1 pulses over 40 ticks", n1, 20);
    check("R6", "uflow0 pulses in joined mode", n0, 0);

    // R5 directed: ratio 01 from fast, reload 2 -> flag every 12 ticks
    do_reset();
    cur_req = "R5";
    wr(3'd0, 8'h02); wr(3'd1, 8'h01); wr(3'd2, 8'h02);
    n0 = 0;
    fast_tick = 1;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk); n0 += uflow0;
    end
    fast_tick = 0;
    check("R5", "uflow0 pulses over 48 fast ticks at /4 reload 2", n0, 4);
    check_counts("R5");

    // R7 directed: three falling edges on evt_raw, reload 5
    do_reset();
    cur_req = "R7";
    wr(3'd0, 8'h0A); wr(3'd1, 8'h03); wr(3'd2, 8'h05);
    fast_tick = 1; slow_tick = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); evt_raw = 0;
      repeat (5) @(negedge clk);
      evt_raw = 1;
      repeat (5) @(negedge clk);
    end
    rd(3'd4, v); check("R7", "count0 after 3 falling edges", v, 3);

    // R8 directed: clean source selected, raw toggles ignored
    cur_req = "R8";
    wr(3'd0, 8'h18);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); evt_raw = 0;
      repeat (5) @(negedge clk);
      evt_raw = 1;
      repeat (5) @(negedge clk);
    end
    rd(3'd4, v); check("R8", "count0 with raw toggles only", v, 3);
    evt_clean = 0; repeat (6) @(negedge clk);
    rd(3'd4, v); check("R8", "count0 after clean falling edge", v, 2);
    evt_clean = 1;

    // R9 directed: pulse width, fast every cycle
    do_reset();
    cur_req = "R9";
    wr(3'd0, 8'h12); wr(3'd2, 8'hF0);
    evt_raw = 0; repeat (3) @(negedge clk);
    fast_tick = 1; repeat (20) @(negedge clk);
    rd(3'd4, v); check("R9", "count0 with input low", v, 0);
    evt_raw = 1; repeat (12) @(negedge clk);
    fast_tick = 0; repeat (3) @(negedge clk);
    check_counts("R9");

    // constrained random phases
    do_reset();
    for (int ph = 0; ph < 16; ph++) begin
      logic [4:0] c;
      c = 5'($urandom);
      if (c[3]) cur_req = c[4] ? "R8" : "R7";
      else if (c[0]) cur_req = "R6";
      else if (c[4]) cur_req = "R9";
      else cur_req = (ph % 2) ? "R3" : "R4";
      rnd_ticks = 1; rnd_evt = 1;
      wr(3'd2, 8'($urandom % 6));
      wr(3'd3, 8'($urandom % 4));
      wr(3'd1, 8'($urandom));
      wr(3'd0, {3'b0, c});
      repeat (400 + ($urandom % 200)) @(negedge clk);
      check_counts(cur_req);
    end
    rnd_ticks = 0; rnd_evt = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule